// File: doc/BRIEF.md
# Indirect Interrupt-Routing Register Window

This block is the software-visible register file of an interrupt router. Software reaches it through two 32-bit bus locations. One is a select register, which holds an index. The other is a data window, which reads or writes the register that the index names. Behind the window sit a version word, a 4-bit identifier and a table of 64-bit routing entries, one per interrupt pin. Each entry takes two consecutive select values, one for its low word and one for its high word.

The table is exported to the pin servicing logic as a flat vector. A one-cycle pulse for each entry reports that its low word has just been rewritten. The servicing logic raises an entry's remote-request flag through a set input, and only a low-word write from the bus clears that flag.

A bus access takes one cycle, qualified by a strobe and a write flag. Read data is registered and returned one cycle after the strobe, under a valid flag. A two-state machine tracks this. `S_IDLE` means no read data is being presented. `S_RDRESP` means read data is being presented. A read strobe in either state moves the machine to (or keeps it in) `S_RDRESP`. Any cycle without a read strobe returns it to `S_IDLE`.

Top module: `irw_window`

## Requirements
- R1: After reset the select register is 0, the identifier is 0, and `rd_valid_o` is 0. Every entry holds only its mask bit (bit 16 set, all other bits 0), and no low-write pulse is active.
- R2: Offset 0x00 is the select register and reads back the last written 32-bit value. Offset 0x10 is the data window. Any other offset reads 0 and ignores writes. Read data appears on `rd_data_o` with `rd_valid_o` high in the cycle after the read strobe.
- R3: Select value 0x00 reads the version word: (pin count − 1) in bits 23:16 and the version code in bits 7:0. With the defaults this is 0x00170011. Window writes at this select value change nothing.
- R4: A window write at select value 0x01 loads write-data bits 27:24 into the identifier. Select values 0x01 and 0x02 both read the identifier in bits 27:24, with all other bits 0. Window writes at select value 0x02 change nothing.
- R5: For select values of 0x10 and above, the entry index is (select − 0x10) >> 1. An even select value accesses bits 31:0 of that entry, and an odd select value accesses bits 63:32. Entry i appears on `entries_o[64*i+63 : 64*i]`.
- R6: A low-word write replaces the entry's bits 31:0 and clears the remote-request flag (bit 14). A high-word write replaces only bits 63:32 and leaves the flag untouched.
- R7: Bit 14 (remote-request) and bit 12 (delivery status) ignore bus write data. Bit 12 always reads 0. Bit 14 is set in the cycle after `rirr_set_i[i]` is high, and it stays set until the next low-word write.
- R8: A window access whose entry index is at or beyond the pin count (select 0x40 and above with the defaults) changes no state, produces no pulse, and reads 0.
- R9: `lo_wr_pulse_o[i]` is high for exactly one cycle, the cycle after a low-word write to entry i, and at most one bit is high at a time.
- R10: If `rirr_set_i[i]` is high in the same cycle as a low-word write to entry i, the entry takes the written word with bit 14 set.
- R11: Select values 0x03 through 0x0F read 0 through the window, and window writes at these values change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read (when `acc_i` is high) |
| off_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read strobe |
| rirr_set_i | input | NPINS | Per-entry remote-request set from the servicing logic |
| entries_o | output | 64*NPINS | All routing entries, entry i at bits 64*i+63:64*i |
| lo_wr_pulse_o | output | NPINS | Per-entry one-cycle pulse after a low-word write |

## Verification
Two updates to the remote-request flag can land on the same clock edge: the clear implied by a bus low-word write, and the set driven by the servicing logic. The bench provokes this by raising `rirr_set_i` for entry 3 in the very cycle that a low-word window write to entry 3 is strobed. It then reads the entry back and expects the written word with bit 14 set. As a counterpart, it checks that a low-word write with no concurrent set clears a flag that was raised earlier.

// File: rtl/irw_pkg.sv
package irw_pkg;

    // bus offsets
    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;

    // indirect indices
    localparam logic [31:0] IDX_VER  = 32'h0000_0000;
    localparam logic [31:0] IDX_ID   = 32'h0000_0001;
    localparam logic [31:0] IDX_ARB  = 32'h0000_0002;
    localparam logic [31:0] IDX_TBL0 = 32'h0000_0010;

    // entry field positions
    localparam int BIT_DSTAT = 12;
    localparam int BIT_RIRR  = 14;
    localparam int BIT_MASK  = 16;
    localparam int ID_LSB    = 24;

    localparam logic [63:0] ENTRY_RST = 64'h1 << BIT_MASK;

    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_RDRESP = 1'b1
    } rd_state_e;

    // merge bus data into a low word: status bits are not writable
    function automatic logic [31:0] lo_merge(input logic [31:0] w, input logic rirr);
        logic [31:0] r;
        r = w;
        r[BIT_DSTAT] = 1'b0;
        r[BIT_RIRR]  = rirr;
        return r;
    endfunction

endpackage

// File: rtl/irw_sel_decode.sv
module irw_sel_decode #(
    parameter int NPINS = 24,
    localparam int IW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [31:0]   sel_i,
    output logic          is_ver_o,
    output logic          is_idr_o,
    output logic          is_ent_o,
    output logic          idr_wr_ok_o,
    output logic [IW-1:0] ent_idx_o,
    output logic          ent_hi_o
);
    import irw_pkg::*;

    logic [31:0] rel;
    logic [30:0] idx_full;

    always_comb begin
        rel         = sel_i - IDX_TBL0;
        idx_full    = rel[31:1];
        is_ver_o    = (sel_i == IDX_VER);
        idr_wr_ok_o = (sel_i == IDX_ID);
        is_idr_o    = (sel_i == IDX_ID) || (sel_i == IDX_ARB);
        is_ent_o    = (sel_i >= IDX_TBL0) && (idx_full < 31'(NPINS));
        ent_idx_o   = idx_full[IW-1:0];
        ent_hi_o    = rel[0];
    end

endmodule

// File: rtl/irw_entry_table.sv
module irw_entry_table #(
    parameter int NPINS = 24,
    localparam int IW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [IW-1:0]       idx_i,
    input  logic [31:0]         wdata_i,
    input  logic [NPINS-1:0]    rirr_set_i,
    output logic [64*NPINS-1:0] entries_o,
    output logic [NPINS-1:0]    lo_wr_pulse_o
);
    import irw_pkg::*;

    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        logic [63:0] ent_q;
        logic        pulse_q;
        logic        hit_lo;
        logic        hit_hi;

        assign hit_lo = wr_lo_i && (idx_i == IW'(g));
        assign hit_hi = wr_hi_i && (idx_i == IW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q   <= ENTRY_RST;
                pulse_q <= 1'b0;
            end else begin
                pulse_q <= hit_lo;
                if (hit_lo) begin
                    ent_q[31:0] <= lo_merge(wdata_i, rirr_set_i[g]);
                end else if (rirr_set_i[g]) begin
                    ent_q[BIT_RIRR] <= 1'b1;
                end
                if (hit_hi) begin
                    ent_q[63:32] <= wdata_i;
                end
            end
        end

        assign entries_o[64*g +: 64] = ent_q;
        assign lo_wr_pulse_o[g]      = pulse_q;

        AST_RIRR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_lo && !rirr_set_i[g]) |=> !ent_q[BIT_RIRR]); // R6
        AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_hi && !hit_lo) |=> ($stable(ent_q[13:0]) && $stable(ent_q[31:15]))); // R6
        AST_RIRR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            rirr_set_i[g] |=> ent_q[BIT_RIRR]); // R10
        AST_DSTAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !ent_q[BIT_DSTAT]); // R7
        AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_q && !hit_lo) |=> !pulse_q); // R9
    end

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lo_wr_pulse_o)); // R9

endmodule

// File: rtl/irw_window.sv
module irw_window #(
    parameter int          NPINS    = 24,
    parameter logic [7:0]  VER_CODE = 8'h11,
    localparam int         IW       = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_i,
    input  logic                wr_i,
    input  logic [7:0]          off_i,
    input  logic [31:0]         wdata_i,
    output logic [31:0]         rd_data_o,
    output logic                rd_valid_o,
    input  logic [NPINS-1:0]    rirr_set_i,
    output logic [64*NPINS-1:0] entries_o,
    output logic [NPINS-1:0]    lo_wr_pulse_o
);
    import irw_pkg::*;

    localparam logic [7:0]  NPM1     = 8'(NPINS - 1);
    localparam logic [31:0] VER_WORD = {8'h00, NPM1, 8'h00, VER_CODE};

    rd_state_e   state_q, state_d;
    logic [31:0] sel_q;
    logic [3:0]  id_q;
    logic [31:0] rdata_q;

    logic          is_ver, is_idr, is_ent, idr_wr_ok, ent_hi;
    logic [IW-1:0] ent_idx;
    logic          bus_wr, bus_rd, win_wr;
    logic [31:0]   win_rd, rd_mux;
    logic [63:0]   ent_arr [NPINS];

    assign bus_wr = acc_i && wr_i;
    assign bus_rd = acc_i && !wr_i;
    assign win_wr = bus_wr && (off_i == OFF_WIN);

    irw_sel_decode #(.NPINS(NPINS)) u_dec (
        .sel_i       (sel_q),
        .is_ver_o    (is_ver),
        .is_idr_o    (is_idr),
        .is_ent_o    (is_ent),
        .idr_wr_ok_o (idr_wr_ok),
        .ent_idx_o   (ent_idx),
        .ent_hi_o    (ent_hi)
    );

    irw_entry_table #(.NPINS(NPINS)) u_tbl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_lo_i       (win_wr && is_ent && !ent_hi),
        .wr_hi_i       (win_wr && is_ent && ent_hi),
        .idx_i         (ent_idx),
        .wdata_i       (wdata_i),
        .rirr_set_i    (rirr_set_i),
        .entries_o     (entries_o),
        .lo_wr_pulse_o (lo_wr_pulse_o)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_arr
        assign ent_arr[g] = entries_o[64*g +: 64];
    end

    // window read multiplexer
    always_comb begin
        if (is_ver) begin
            win_rd = VER_WORD;
        end else if (is_idr) begin
            win_rd = {4'h0, id_q, 24'h0};
        end else if (is_ent) begin
            win_rd = ent_hi ? ent_arr[ent_idx][63:32] : ent_arr[ent_idx][31:0];
        end else begin
            win_rd = 32'h0;
        end
        unique case (off_i)
            OFF_SEL: rd_mux = sel_q;
            OFF_WIN: rd_mux = win_rd;
            default: rd_mux = 32'h0;
        endcase
    end

    // select and identifier registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 32'h0;
            id_q  <= 4'h0;
        end else begin
            if (bus_wr && (off_i == OFF_SEL)) begin
                sel_q <= wdata_i;
            end
            if (win_wr && idr_wr_ok) begin
                id_q <= wdata_i[ID_LSB +: 4];
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rdata_q <= 32'h0;
        end else begin
            state_q <= state_d;
            if (bus_rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = bus_rd ? S_RDRESP : S_IDLE;
            S_RDRESP: state_d = bus_rd ? S_RDRESP : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_valid_o = (state_q == S_RDRESP);
        rd_data_o  = rd_valid_o ? rdata_q : 32'h0;
    end

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rd_valid_o); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !rd_valid_o); // R2
    AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && off_i == OFF_SEL && !(bus_wr)) |=> (rd_data_o == $past(sel_q))); // R2
    AST_ID_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_wr && idr_wr_ok) |=> $stable(id_q)); // R4

endmodule

// File: tb/irw_window_tb.sv
`timescale 1ns/1ps
module irw_window_tb;
    localparam int NP = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc = 1'b0;
    logic            wr = 1'b0;
    logic [7:0]      off = 8'h0;
    logic [31:0]     wdata = 32'h0;
    logic [31:0]     rdata;
    logic            rvalid;
    logic [NP-1:0]   rirr = '0;
    logic [64*NP-1:0] ents;
    logic [NP-1:0]   pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        int          req;
    } sb_t;
    sb_t sbq[$];

    always #4 clk = ~clk;

    irw_window u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_i         (acc),
        .wr_i          (wr),
        .off_i         (off),
        .wdata_i       (wdata),
        .rd_data_o     (rdata),
        .rd_valid_o    (rvalid),
        .rirr_set_i    (rirr),
        .entries_o     (ents),
        .lo_wr_pulse_o (pulse)
    );

    task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard items as read data appears
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (sbq.size() == 0) begin
                chk(2, {32'h0, rdata}, 64'hDEAD); // R2 unexpected read data
            end else begin
                sb_t it;
                it = sbq.pop_front();
                chk(it.req, {32'h0, rdata}, {32'h0, it.exp});
            end
        end
    end

    task automatic bus_wr(input logic [7:0] o, input logic [31:0] d);
        @(negedge clk);
        acc = 1'b1; wr = 1'b1; off = o; wdata = d;
        @(negedge clk);
        acc = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] o, input logic [31:0] e, input int req);
        sb_t it;
        @(negedge clk);
        acc = 1'b1; wr = 1'b0; off = o;
        it.exp = e; it.req = req;
        sbq.push_back(it);
        @(negedge clk);
        acc = 1'b0;
    endtask

    task automatic sel(input logic [31:0] v);
        bus_wr(8'h00, v);
    endtask

    function automatic logic [63:0] ent(input int i);
        return ents[64*i +: 64];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(1, {63'h0, rvalid}, 64'h0);
        chk(1, ent(0), 64'h0000_0000_0001_0000);
        chk(1, ent(NP-1), 64'h0000_0000_0001_0000);
        chk(1, {40'h0, pulse}, 64'h0);
        bus_rd(8'h00, 32'h0, 1);          // R1 select is 0
        bus_rd(8'h10, 32'h0000_0000, 1);  // R1 identifier is 0 (select 1 tested below)
        // R3 version at select 0 (the read above targets select 0 => version)
        sbq[sbq.size()-1].exp = 32'h0017_0011;
        sbq[sbq.size()-1].req = 3;

        // R2 select readback and unused offsets
        sel(32'h1234_5678);
        bus_rd(8'h00, 32'h1234_5678, 2);
        bus_rd(8'h20, 32'h0, 2);
        bus_wr(8'h04, 32'hFFFF_FFFF);     // R2 ignored offset
        bus_rd(8'h00, 32'h1234_5678, 2);

        // R3 version writes ignored
        sel(32'h0);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        bus_rd(8'h10, 32'h0017_0011, 3);

        // R4 identifier
        sel(32'h1);
        bus_wr(8'h10, 32'hA5FF_FFFF);
        bus_rd(8'h10, 32'h0500_0000, 4);
        sel(32'h2);
        bus_rd(8'h10, 32'h0500_0000, 4);
        bus_wr(8'h10, 32'h0F00_0000);
        bus_rd(8'h10, 32'h0500_0000, 4);
        sel(32'h1);
        bus_rd(8'h10, 32'h0500_0000, 4);

        // R11 reserved indices
        sel(32'h3);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        bus_rd(8'h10, 32'h0, 11);
        sel(32'h0F);
        bus_rd(8'h10, 32'h0, 11);
        chk(11, ent(0), 64'h0000_0000_0001_0000);

        // R5 R6 R7 R9 entry 5 (select 0x1A low, 0x1B high)
        sel(32'h1A);
        bus_wr(8'h10, 32'h0000_F0F5);
        chk(9, {40'h0, pulse}, 64'h1 << 5);
        @(negedge clk);
        chk(9, {40'h0, pulse}, 64'h0);
        bus_rd(8'h10, 32'h0000_A0F5, 7);  // R7 bits 14 and 12 not writable
        sel(32'h1B);
        bus_wr(8'h10, 32'hC300_0000);
        chk(9, {40'h0, pulse}, 64'h0);    // R9 no pulse on high write
        bus_rd(8'h10, 32'hC300_0000, 5);
        chk(5, ent(5), 64'hC300_0000_0000_A0F5);
        @(negedge clk); rirr = NP'(1) << 5;
        @(negedge clk); rirr = '0;
        chk(7, ent(5), 64'hC300_0000_0000_E0F5);
        bus_wr(8'h10, 32'h1100_0000);     // R6 high write keeps flag
        sel(32'h1A);
        bus_rd(8'h10, 32'h0000_E0F5, 6);
        bus_wr(8'h10, 32'h0000_80F5);     // R6 low write clears flag
        bus_rd(8'h10, 32'h0000_80F5, 6);
        chk(6, ent(5), 64'h1100_0000_0000_80F5);

        // R5 last entry (select 0x3E / 0x3F)
        sel(32'h3E);
        bus_wr(8'h10, 32'h0000_0012);
        chk(9, {40'h0, pulse}, 64'h1 << (NP-1));
        sel(32'h3F);
        bus_wr(8'h10, 32'h7700_0000);
        chk(5, ent(NP-1), 64'h7700_0000_0000_0012);

        // R8 out of range index
        sel(32'h40);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        chk(8, {40'h0, pulse}, 64'h0);
        bus_rd(8'h10, 32'h0, 8);
        chk(8, ent(0), 64'h0000_0000_0001_0000);
        chk(8, ent(NP-1), 64'h7700_0000_0000_0012);
        sel(32'h41);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        chk(8, ent(NP-1), 64'h7700_0000_0000_0012);

        // R10 set and low write in the same cycle on entry 3 (select 0x16)
        sel(32'h16);
        @(negedge clk);
        acc = 1'b1; wr = 1'b1; off = 8'h10; wdata = 32'h0000_0030;
        rirr = NP'(1) << 3;
        @(negedge clk);
        acc = 1'b0; wr = 1'b0; rirr = '0;
        chk(10, ent(3), 64'h0000_0000_0000_4030);
        bus_rd(8'h10, 32'h0000_4030, 10);

        repeat (3) @(negedge clk);
        chk(2, 64'(sbq.size()), 64'h0);   // R2 every read returned
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule